// File: doc/BRIEF.md
# Two-Size Banked Translation Buffer with Superpage Promotion

This block translates virtual page numbers to physical page numbers for a small embedded core. Base-page translations live in two fully associative banks of equal size. The lowest bit of the virtual page number selects a bank, and only that bank's tags are compared, which keeps the comparator activity per lookup to half the base-page capacity. A third fully associative array holds superpage translations, each covering four adjacent base pages. It is compared in parallel with the selected bank, using the virtual page number with its two low bits dropped.

Translations enter only through the refill port as base pages. After each accepted refill, the block checks the four-page group that holds the refilled page. If all four pages of that group are resident and map to four consecutive physical pages starting on a four-page boundary, the block writes one superpage entry and invalidates the four bank entries on the same clock edge. This frees bank slots and evens out bank usage. A flush input clears every translation in one cycle.

Top module: `bp_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses, and a miss returns physical page 0.
- R2: A lookup presented with `lk_valid` high is answered on `lk_hit`/`lk_ppn` on the following cycle. A cycle with `lk_valid` low yields `lk_hit` 0 and `lk_ppn` 0 on the next cycle.
- R3: A refill is written into bank `rf_vpn[0]` only. Each bank holds 8 entries and replaces them in round-robin order, so the ninth distinct refill into one bank evicts that bank's first entry and leaves the other bank untouched.
- R4: A refill whose page is already resident in its bank overwrites that entry in place and does not advance the bank's replacement pointer.
- R5: Promotion occurs when all four pages of a group (virtual pages sharing every bit above bit 1) are resident, and page k of the group (k = its two low bits) maps to physical page P+k, where P has its two low bits zero. The cycle after the refill that completes the group, the block writes one superpage entry and removes all four bank entries. The group then survives eviction of the banks.
- R6: A group whose physical pages are not consecutive in order, or whose base is not a multiple of four, is not promoted and stays in the banks.
- R7: A superpage hit returns the superpage's physical base with the lookup's two low virtual page bits placed in the low two bits, and it takes priority over a bank result.
- R8: A refill of a page already covered by a valid superpage is discarded, and lookups keep returning the superpage translation.
- R9: The superpage array holds 8 entries with round-robin replacement, so the ninth promotion evicts the first superpage.
- R10: Flush clears all valid bits and resets the replacement pointers in one cycle. A lookup in the flush cycle misses, and a refill in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all translations |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_hit | output | 1 | Registered lookup hit |
| lk_ppn | output | PPN_W | Registered physical page number (0 on miss) |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_ppn | input | PPN_W | Refill physical page number |

## Verification
The assertions that a translation is never resident in both a bank and the superpage array, and that no page matches twice, depend on one condition: no refill arrives in the cycle in which a promotion check for an earlier refill runs. A refill landing in that cycle could place a page that the same edge promotes. To meet this condition, the stimulus follows every refill with at least one idle cycle. Promotion itself is observed only at the ports: after a group is promoted, the bench overwrites the affected bank with unrelated refills and checks that the group's pages still translate. It also checks that refills to covered pages leave the superpage result unchanged.

// File: rtl/bp_tlb.sv
module bp_tlb #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn
);
  localparam int SPB = 2;
  localparam int GRP = 1 << SPB;
  localparam int IW  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int GW  = VPN_W - SPB;
  localparam int SW  = PPN_W - SPB;

  logic [VPN_W-1:0] b_tag [2][ENTRIES];
  logic [PPN_W-1:0] b_pg  [2][ENTRIES];
  logic [ENTRIES-1:0] b_v [2];
  logic [IW-1:0]    b_ptr [2];
  logic [GW-1:0]    s_tag [ENTRIES];
  logic [SW-1:0]    s_pg  [ENTRIES];
  logic [ENTRIES-1:0] s_v;
  logic [IW-1:0]    s_ptr;
  logic             pend;
  logic [GW-1:0]    pend_grp;

  // lookup: one bank plus the superpage array
  logic             lsel;
  logic [ENTRIES-1:0] lbm, lsm;
  logic [PPN_W-1:0] bppn;
  logic [SW-1:0]    sppn;
  logic             bhit, shit;

  assign lsel = lk_vpn[0];

  always_comb begin
    bppn = '0;
    sppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lbm[i] = b_v[lsel][i] && (b_tag[lsel][i] == lk_vpn);
      lsm[i] = s_v[i] && (s_tag[i] == lk_vpn[VPN_W-1:SPB]);
      if (lbm[i]) bppn = bppn | b_pg[lsel][i];
      if (lsm[i]) sppn = sppn | s_pg[i];
    end
  end

  assign bhit = |lbm;
  assign shit = |lsm;

  // refill placement
  logic             rsel, rcov, rexist, racc;
  logic [ENTRIES-1:0] rbm;
  logic [IW-1:0]    ridx;

  assign rsel = rf_vpn[0];

  always_comb begin
    rcov = 1'b0;
    ridx = b_ptr[rsel];
    for (int i = 0; i < ENTRIES; i++) begin
      rbm[i] = b_v[rsel][i] && (b_tag[rsel][i] == rf_vpn);
      if (rbm[i]) ridx = IW'(i);
      if (s_v[i] && (s_tag[i] == rf_vpn[VPN_W-1:SPB])) rcov = 1'b1;
    end
  end

  assign rexist = |rbm;
  assign racc   = rf_valid && !rcov;

  // promotion check on the group of the last refill
  logic [GRP-1:0]   pf;
  logic [IW-1:0]    pidx [GRP];
  logic [PPN_W-1:0] pppn [GRP];
  logic             promo;

  always_comb begin
    promo = pend;
    for (int k = 0; k < GRP; k++) begin
      pf[k]   = 1'b0;
      pidx[k] = '0;
      pppn[k] = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (b_v[k % 2][i] && (b_tag[k % 2][i] == {pend_grp, SPB'(k)})) begin
          pf[k]   = 1'b1;
          pidx[k] = IW'(i);
          pppn[k] = b_pg[k % 2][i];
        end
      end
      if (!pf[k] || pppn[k][SPB-1:0] != SPB'(k) ||
          pppn[k][PPN_W-1:SPB] != pppn[0][PPN_W-1:SPB])
        promo = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit   <= 1'b0;
      lk_ppn   <= '0;
      pend     <= 1'b0;
      pend_grp <= '0;
      s_v      <= '0;
      s_ptr    <= '0;
      for (int b = 0; b < 2; b++) begin
        b_v[b]   <= '0;
        b_ptr[b] <= '0;
      end
    end else if (flush) begin
      lk_hit <= 1'b0;
      lk_ppn <= '0;
      pend   <= 1'b0;
      s_v    <= '0;
      s_ptr  <= '0;
      for (int b = 0; b < 2; b++) begin
        b_v[b]   <= '0;
        b_ptr[b] <= '0;
      end
    end else begin
      lk_hit   <= lk_valid && (bhit || shit);
      lk_ppn   <= !lk_valid ? '0 :
                  shit ? {sppn, lk_vpn[SPB-1:0]} :
                  bhit ? bppn : '0;
      pend     <= racc;
      pend_grp <= rf_vpn[VPN_W-1:SPB];

      if (promo) begin
        s_tag[s_ptr] <= pend_grp;
        s_pg[s_ptr]  <= pppn[0][PPN_W-1:SPB];
        s_v[s_ptr]   <= 1'b1;
        s_ptr        <= (s_ptr == IW'(ENTRIES-1)) ? '0 : s_ptr + 1'b1;
        for (int k = 0; k < GRP; k++)
          b_v[k % 2][pidx[k]] <= 1'b0;
      end

      if (racc) begin
        b_tag[rsel][ridx] <= rf_vpn;
        b_pg[rsel][ridx]  <= rf_ppn;
        b_v[rsel][ridx]   <= 1'b1;
        if (!rexist)
          b_ptr[rsel] <= (b_ptr[rsel] == IW'(ENTRIES-1)) ? '0 : b_ptr[rsel] + 1'b1;
      end
    end
  end

  assert_flush_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_hit && lk_ppn == '0));

  assert_bank_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(lbm));

  assert_super_unique_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(lsm));

  assert_no_dual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> !(bhit && shit));

  assert_promo_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (promo && !flush) |=> (s_v != '0));
endmodule

// File: tb/tb_bp_tlb.sv
`timescale 1ns/1ps
module tb_bp_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic        rf_valid = 1'b0;
  logic [19:0] rf_vpn = '0;
  logic [19:0] rf_ppn = '0;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bp_tlb dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn)
  );

  task automatic chk(string req, logic ah, logic [19:0] ap, logic eh, logic [19:0] ep);
    tests++;
    if (ah !== eh || ap !== ep) begin
      fails++;
      $display("FAIL %s: hit=%0b ppn=%h expected hit=%0b ppn=%h", req, ah, ap, eh, ep);
    end
  endtask

  task automatic refill(logic [19:0] v, logic [19:0] p);
    @(negedge clk); rf_valid = 1'b1; rf_vpn = v; rf_ppn = p;
    @(negedge clk); rf_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic lookup(string req, logic [19:0] v, logic eh, logic [19:0] ep);
    @(negedge clk); lk_valid = 1'b1; lk_vpn = v;
    @(negedge clk); lk_valid = 1'b0;
    chk(req, lk_hit, lk_ppn, eh, ep);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic fill_evens(logic [19:0] base);
    for (int i = 0; i < 8; i++) refill(base + 20'(2*i), 20'h5000 + 20'(i));
  endtask

  task automatic t_reset();
    lookup("R1", 20'h0, 1'b0, 20'h0);
    lookup("R1", 20'h123, 1'b0, 20'h0);
  endtask

  task automatic t_bank_rr();
    do_flush();
    refill(20'h101, 20'h1101);
    for (int i = 0; i < 9; i++) refill(20'h200 + 20'(2*i), 20'h2000 + 20'(i));
    lookup("R3", 20'h200, 1'b0, 20'h0);
    lookup("R3", 20'h202, 1'b1, 20'h2001);
    lookup("R3", 20'h210, 1'b1, 20'h2008);
    lookup("R3", 20'h101, 1'b1, 20'h1101);
  endtask

  task automatic t_inplace();
    do_flush();
    refill(20'h300, 20'h00A);
    refill(20'h300, 20'h00B);
    lookup("R4", 20'h300, 1'b1, 20'h00B);
    for (int i = 1; i < 8; i++) refill(20'h300 + 20'(2*i), 20'h3000 + 20'(i));
    lookup("R4", 20'h300, 1'b1, 20'h00B);
  endtask

  task automatic t_promote();
    do_flush();
    for (int k = 0; k < 4; k++) refill(20'h400 + 20'(k), 20'h800 + 20'(k));
    fill_evens(20'h500);
    lookup("R5", 20'h400, 1'b1, 20'h800);
    lookup("R7", 20'h402, 1'b1, 20'h802);
    lookup("R7", 20'h403, 1'b1, 20'h803);
    refill(20'h401, 20'hABC);
    lookup("R8", 20'h401, 1'b1, 20'h801);
  endtask

  task automatic t_nopromo();
    do_flush();
    refill(20'h600, 20'h900); refill(20'h601, 20'h901);
    refill(20'h602, 20'h903); refill(20'h603, 20'h902);
    lookup("R6", 20'h602, 1'b1, 20'h903);
    fill_evens(20'h700);
    lookup("R6", 20'h600, 1'b0, 20'h0);
    lookup("R6", 20'h601, 1'b1, 20'h901);
    do_flush();
    for (int k = 0; k < 4; k++) refill(20'h610 + 20'(k), 20'h901 + 20'(k));
    fill_evens(20'h700);
    lookup("R6", 20'h610, 1'b0, 20'h0);
    lookup("R6", 20'h613, 1'b1, 20'h904);
  endtask

  task automatic t_super_rr();
    do_flush();
    for (int g = 0; g < 9; g++)
      for (int k = 0; k < 4; k++)
        refill(20'h1000 + 20'(4*g + k), 20'h4000 + 20'(4*g + k));
    lookup("R9", 20'h1001, 1'b0, 20'h0);
    lookup("R9", 20'h1005, 1'b1, 20'h4005);
    lookup("R9", 20'h1022, 1'b1, 20'h4022);
  endtask

  task automatic t_flush();
    do_flush();
    refill(20'h800, 20'h055);
    @(negedge clk); lk_valid = 1'b1; lk_vpn = 20'h800; flush = 1'b1;
    @(negedge clk); lk_valid = 1'b0; flush = 1'b0;
    chk("R10", lk_hit, lk_ppn, 1'b0, 20'h0);
    lookup("R10", 20'h800, 1'b0, 20'h0);
    @(negedge clk); rf_valid = 1'b1; rf_vpn = 20'h804; rf_ppn = 20'h066; flush = 1'b1;
    @(negedge clk); rf_valid = 1'b0; flush = 1'b0;
    lookup("R10", 20'h804, 1'b0, 20'h0);
    for (int k = 0; k < 4; k++) refill(20'h810 + 20'(k), 20'h120 + 20'(k));
    lookup("R10", 20'h811, 1'b1, 20'h121);
    do_flush();
    lookup("R10", 20'h811, 1'b0, 20'h0);
  endtask

  task automatic t_idle();
    do_flush();
    refill(20'h900, 20'h077);
    lookup("R2", 20'h900, 1'b1, 20'h077);
    @(negedge clk);
    chk("R2", lk_hit, lk_ppn, 1'b0, 20'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bank_rr();
    t_inplace();
    t_promote();
    t_nopromo();
    t_super_rr();
    t_flush();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1..: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule